// File: doc/BRIEF.md
# Hashed Page-Table Group Address Generator

This block turns a translation request into the two values needed to search a hashed page table. It takes a segment descriptor (a virtual segment identifier and a large-page flag), an effective address, the table register (base address plus a 5-bit size code) and a flag that picks the primary or the secondary group. It returns the physical address of the 128-byte entry group to fetch, and the abbreviated virtual page number that the entries in that group are later compared against.

The arithmetic is combinational. A parameter adds an output register, which gives one cycle of latency. A valid strobe travels with the request. Fetching the group and comparing the entries are done outside this block. All widths, bit positions and page shifts are parameters with 64-bit defaults.

Top module: `hpt_group_gen`

## Requirements
- R1: The page index is taken from the low 28 bits of the effective address only. It is EA[27:12] for a small (4 KB) page and EA[27:24] for a large (16 MB) page, zero-extended. Bits 63:28 of the effective address have no effect on either output.
- R2: The hash is the segment identifier XOR the page index. When `sel_second` is 1 every bit of that hash is inverted before masking.
- R3: The size code is `tbl_reg[4:0]`. The hash is ANDed with a table mask that has ones in bits 0 to (size + 11) − 1 and zeros above.
- R4: `group_addr` is `tbl_reg[63:18]` placed at bits 63:18, ORed with the masked hash shifted left by 7. Bits 6:0 of `group_addr` are always zero, and `tbl_reg[17:5]` has no effect.
- R5: For a small page, `avpn` = ((vsid << 16) | page index) >> 4, computed in 64 bits.
- R6: For a large page, `avpn` = ((vsid << 4) | page index) << 8, computed in 64 bits, so `avpn[7:0]` is zero.
- R7: With the output register present (default), `out_valid` is `in_valid` delayed by one clock. Outputs change only after a cycle where `in_valid` is 1 and otherwise hold their last value, whatever the inputs do.
- R8: While `rst_n` is low, `out_valid`, `group_addr` and `avpn` are all zero.
- R9: The hash never contributes above bit 38 before the shift by 7. With size codes 28 to 31 the 39-bit limit decides the mask, not the size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| vsid | input | 52 | Virtual segment identifier of the matched segment |
| large_pg | input | 1 | 1 = segment uses 16 MB pages, 0 = 4 KB pages |
| ea | input | 64 | Effective address |
| tbl_reg | input | 64 | Table base (bits 63:18) and size code (bits 4:0) |
| sel_second | input | 1 | 1 = secondary group (inverted hash) |
| out_valid | output | 1 | Result strobe |
| group_addr | output | 64 | Physical address of the 128-byte entry group |
| avpn | output | 64 | Abbreviated virtual page number for entry compare |

## Verification
The same descriptor and address are sent once with the primary select and once with the secondary select. A wrong or missing inversion then shows up as a pair of results that do not complement each other under the mask. Small-page and large-page requests with the same identifier tell the two index extractions and the two opposite AVPN alignments apart. Size codes 0 and 31 test the two ends of the table mask: the narrow mask and the point where the fixed 39-bit limit takes over. Further requests set the high effective-address bits and the spare bits of the table register, which must not change the results. Idle gaps with changing inputs check that the registered outputs hold.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic {
      PG_SMALL = 1'b0,
      PG_LARGE = 1'b1
   } pg_size_e;

   localparam int HPT_ADDR_W      = 64;
   localparam int HPT_VSID_W      = 52;
   localparam int HPT_SEG_BITS    = 28;
   localparam int HPT_SMALL_SHIFT = 12;
   localparam int HPT_LARGE_SHIFT = 24;
endpackage

// File: rtl/hpt_page_index.sv
module hpt_page_index #(
   parameter int SEG_BITS    = 28,
   parameter int SMALL_SHIFT = 12,
   parameter int LARGE_SHIFT = 24,
   parameter int IDX_W       = SEG_BITS - SMALL_SHIFT
) (
   input  logic [SEG_BITS-1:0]   seg_off,
   input  hpt_pkg::pg_size_e     pg_size,
   output logic [IDX_W-1:0]      page_idx
);
   localparam int SMALL_W = SEG_BITS - SMALL_SHIFT;
   localparam int LARGE_W = SEG_BITS - LARGE_SHIFT;

   if (SMALL_W != IDX_W) begin : g_bad_idx
      $error("hpt_page_index: IDX_W must equal SEG_BITS - SMALL_SHIFT");
   end
   if (LARGE_SHIFT <= SMALL_SHIFT || LARGE_SHIFT >= SEG_BITS) begin : g_bad_shift
      $error("hpt_page_index: shifts must satisfy SMALL < LARGE < SEG_BITS");
   end

   logic [SMALL_W-1:0] idx_small;
   logic [LARGE_W-1:0] idx_large;
   logic               seg_off_unused_lo;

   assign idx_small         = seg_off[SEG_BITS-1:SMALL_SHIFT];
   assign idx_large         = seg_off[SEG_BITS-1:LARGE_SHIFT];
   assign seg_off_unused_lo = ^seg_off[SMALL_SHIFT-1:0];

   always_comb begin
      if (pg_size == hpt_pkg::PG_LARGE) page_idx = IDX_W'(idx_large);
      else                              page_idx = idx_small;
   end
endmodule

// File: rtl/hpt_hash_mask.sv
module hpt_hash_mask #(
   parameter int ADDR_W      = 64,
   parameter int VSID_W      = 52,
   parameter int IDX_W       = 16,
   parameter int HASH_W      = 39,
   parameter int SIZE_W      = 5,
   parameter int SIZE_BIAS   = 11,
   parameter int GROUP_SHIFT = 7,
   parameter int BASE_LSB    = 18
) (
   input  logic [VSID_W-1:0]          vsid,
   input  logic [IDX_W-1:0]           page_idx,
   input  logic                       sel_second,
   input  logic [SIZE_W-1:0]          tsize,
   input  logic [ADDR_W-BASE_LSB-1:0] tbase_hi,
   output logic [ADDR_W-1:0]          group_addr,
   output logic [ADDR_W-1:0]          hash_masked
);
   if (VSID_W > ADDR_W || IDX_W > ADDR_W) begin : g_bad_w
      $error("hpt_hash_mask: operands wider than ADDR_W");
   end
   if (HASH_W + GROUP_SHIFT > ADDR_W) begin : g_bad_hash
      $error("hpt_hash_mask: shifted hash exceeds ADDR_W");
   end
   if (BASE_LSB < GROUP_SHIFT) begin : g_bad_base
      $error("hpt_hash_mask: base must sit at or above the group shift");
   end

   logic [ADDR_W-1:0] hash_raw;
   logic [ADDR_W-1:0] hash_sel;
   logic [ADDR_W-1:0] tmask;
   logic [31:0]       mask_lim;

   assign hash_raw = ADDR_W'(vsid) ^ ADDR_W'(page_idx);
   assign hash_sel = sel_second ? ~hash_raw : hash_raw;
   assign mask_lim = 32'(tsize) + 32'(SIZE_BIAS);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      if (i < HASH_W) begin : g_in_cap
         assign tmask[i] = (32'(i) < mask_lim);
      end else begin : g_above_cap
         assign tmask[i] = 1'b0;
      end
   end

   assign hash_masked = hash_sel & tmask;
   assign group_addr  = {tbase_hi, {BASE_LSB{1'b0}}} | (hash_masked << GROUP_SHIFT);
endmodule

// File: rtl/hpt_avpn_align.sv
module hpt_avpn_align #(
   parameter int ADDR_W      = 64,
   parameter int VSID_W      = 52,
   parameter int IDX_W       = 16,
   parameter int SEG_BITS    = 28,
   parameter int SMALL_SHIFT = 12,
   parameter int LARGE_SHIFT = 24,
   parameter int VA_BITS     = 80,
   parameter int AVPN_TOP    = 56,
   parameter int AVPN_LIFT   = 8
) (
   input  logic [VSID_W-1:0]  vsid,
   input  logic [IDX_W-1:0]   page_idx,
   input  hpt_pkg::pg_size_e  pg_size,
   output logic [ADDR_W-1:0]  avpn
);
   localparam int AVPN_DROP = (VA_BITS - SMALL_SHIFT) - AVPN_TOP - AVPN_LIFT;

   if (AVPN_DROP < 0 || AVPN_DROP >= IDX_W) begin : g_bad_drop
      $error("hpt_avpn_align: derived right shift out of range");
   end

   logic [ADDR_W-1:0] pre_small;
   logic [ADDR_W-1:0] pre_large;

   assign pre_small = (ADDR_W'(vsid) << (SEG_BITS - SMALL_SHIFT)) | ADDR_W'(page_idx);
   assign pre_large = (ADDR_W'(vsid) << (SEG_BITS - LARGE_SHIFT)) | ADDR_W'(page_idx);

   always_comb begin
      if (pg_size == hpt_pkg::PG_LARGE) avpn = pre_large << AVPN_LIFT;
      else                              avpn = pre_small >> AVPN_DROP;
   end
endmodule

// File: rtl/hpt_group_gen.sv
module hpt_group_gen #(
   parameter int ADDR_W      = hpt_pkg::HPT_ADDR_W,
   parameter int VSID_W      = hpt_pkg::HPT_VSID_W,
   parameter int SEG_BITS    = hpt_pkg::HPT_SEG_BITS,
   parameter int SMALL_SHIFT = hpt_pkg::HPT_SMALL_SHIFT,
   parameter int LARGE_SHIFT = hpt_pkg::HPT_LARGE_SHIFT,
   parameter int HASH_W      = 39,
   parameter int SIZE_W      = 5,
   parameter int SIZE_BIAS   = 11,
   parameter int GROUP_SHIFT = 7,
   parameter int BASE_LSB    = 18,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VSID_W-1:0] vsid,
   input  logic              large_pg,
   input  logic [ADDR_W-1:0] ea,
   input  logic [ADDR_W-1:0] tbl_reg,
   input  logic              sel_second,
   output logic              out_valid,
   output logic [ADDR_W-1:0] group_addr,
   output logic [ADDR_W-1:0] avpn
);
   localparam int IDX_W     = SEG_BITS - SMALL_SHIFT;
   localparam int LARGE_W   = SEG_BITS - LARGE_SHIFT;
   localparam int AVPN_DROP = (80 - SMALL_SHIFT) - 56 - 8;

   if (ADDR_W < SEG_BITS || BASE_LSB <= SIZE_W || BASE_LSB >= ADDR_W) begin : g_bad_top
      $error("hpt_group_gen: inconsistent field layout");
   end

   hpt_pkg::pg_size_e  pg_size;
   logic [IDX_W-1:0]   page_idx;
   logic [ADDR_W-1:0]  grp_c;
   logic [ADDR_W-1:0]  avpn_c;
   logic [ADDR_W-1:0]  hash_masked;
   logic               ea_unused_hi;
   logic               tbl_unused_mid;

   assign pg_size        = large_pg ? hpt_pkg::PG_LARGE : hpt_pkg::PG_SMALL;
   assign ea_unused_hi   = ^ea[ADDR_W-1:SEG_BITS];
   assign tbl_unused_mid = ^tbl_reg[BASE_LSB-1:SIZE_W];

   hpt_page_index #(
      .SEG_BITS(SEG_BITS), .SMALL_SHIFT(SMALL_SHIFT),
      .LARGE_SHIFT(LARGE_SHIFT), .IDX_W(IDX_W)
   ) u_idx (
      .seg_off (ea[SEG_BITS-1:0]),
      .pg_size (pg_size),
      .page_idx(page_idx)
   );

   hpt_hash_mask #(
      .ADDR_W(ADDR_W), .VSID_W(VSID_W), .IDX_W(IDX_W), .HASH_W(HASH_W),
      .SIZE_W(SIZE_W), .SIZE_BIAS(SIZE_BIAS), .GROUP_SHIFT(GROUP_SHIFT),
      .BASE_LSB(BASE_LSB)
   ) u_hash (
      .vsid       (vsid),
      .page_idx   (page_idx),
      .sel_second (sel_second),
      .tsize      (tbl_reg[SIZE_W-1:0]),
      .tbase_hi   (tbl_reg[ADDR_W-1:BASE_LSB]),
      .group_addr (grp_c),
      .hash_masked(hash_masked)
   );

   hpt_avpn_align #(
      .ADDR_W(ADDR_W), .VSID_W(VSID_W), .IDX_W(IDX_W), .SEG_BITS(SEG_BITS),
      .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
   ) u_avpn (
      .vsid    (vsid),
      .page_idx(page_idx),
      .pg_size (pg_size),
      .avpn    (avpn_c)
   );

   // R9: the hash feeding the group address never reaches past the cap
   always_comb begin
      if (rst_n && in_valid) begin
         assert_hash_cap_R9: assert (hash_masked[ADDR_W-1:HASH_W] == '0)
            else $error("hash wider than cap");
      end
   end

   // R1: a large page leaves only the top index bits populated
   always_comb begin
      if (rst_n && in_valid && large_pg) begin
         assert_large_idx_R1: assert (page_idx[IDX_W-1:LARGE_W] == '0)
            else $error("large page index too wide");
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            group_addr <= '0;
            avpn       <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               group_addr <= grp_c;
               avpn       <= avpn_c;
            end
         end
      end

      assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(group_addr) && $stable(avpn)));
      assert_grp_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (group_addr[GROUP_SHIFT-1:0] == '0));
      assert_small_avpn_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !large_pg) |=>
            (avpn[IDX_W-AVPN_DROP-1:0] == $past(page_idx[IDX_W-1:AVPN_DROP])));
      assert_large_avpn_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && large_pg) |=>
            (avpn[7:0] == 8'h00 && avpn[8+LARGE_W-1:8] == $past(page_idx[LARGE_W-1:0])));
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign group_addr = grp_c;
      assign avpn       = avpn_c;

      assert_grp_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (group_addr[GROUP_SHIFT-1:0] == '0));
   end
endmodule

// File: tb/hpt_group_gen_bench.sv
module hpt_group_gen_bench;
   typedef struct {
      logic [63:0] g;
      logic [63:0] a;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [51:0] vsid = '0;
   logic        large_pg = 1'b0;
   logic [63:0] ea = '0;
   logic [63:0] tbl_reg = '0;
   logic        sel_second = 1'b0;
   logic        out_valid;
   logic [63:0] group_addr;
   logic [63:0] avpn;

   int   n_checks = 0;
   int   n_fails  = 0;
   exp_t sb[$];
   logic [63:0] last_g = '0;
   logic [63:0] last_a = '0;
   bit   seen_any = 1'b0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   hpt_group_gen u_hpt_group_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vsid(vsid),
      .large_pg(large_pg), .ea(ea), .tbl_reg(tbl_reg), .sel_second(sel_second),
      .out_valid(out_valid), .group_addr(group_addr), .avpn(avpn)
   );

   task automatic check64(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [51:0] v, input logic lg,
                                 input logic [63:0] e, input logic [63:0] t,
                                 input logic sec,
                                 output logic [63:0] g, output logic [63:0] a);
      int          sh;
      logic [63:0] pg, h, v64;
      sh  = lg ? 24 : 12;
      v64 = {12'h000, v};
      pg  = (e & 64'h0000_0000_0FFF_FFFF) >> sh;
      h   = v64 ^ pg;
      if (sec) h = ~h;
      h   = h & ((64'h1 << 39) - 64'h1);
      h   = h & ((64'h1 << (int'(t[4:0]) + 11)) - 64'h1);
      g   = (t & 64'hFFFF_FFFF_FFFC_0000) | (h << 7);
      a   = pg | (v64 << (28 - sh));
      if (sh < 24) a = a >> 4;
      else         a = a << 8;
   endfunction

   task automatic drive(input logic [51:0] v, input logic lg, input logic [63:0] e,
                        input logic [63:0] t, input logic sec, input string tag);
      exp_t it;
      @(negedge clk);
      vsid = v; large_pg = lg; ea = e; tbl_reg = t; sel_second = sec;
      in_valid = 1'b1;
      model(v, lg, e, t, sec, it.g, it.a);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         ea       = {$urandom, $urandom};
         vsid     = {$urandom, $urandom};
         large_pg = ~large_pg;
         sel_second = ~sel_second;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         check64("R8", "reset out_valid", {63'd0, out_valid}, 64'd0);
         check64("R8", "reset group_addr", group_addr, 64'd0);
         check64("R8", "reset avpn", avpn, 64'd0);
      end else if (out_valid) begin
         if (sb.size() == 0) begin
            n_checks++; n_fails++;
            $display("FAIL R7 unexpected out_valid: actual 1 expected 0");
         end else begin
            exp_t it;
            it = sb.pop_front();
            check64(it.tag, "group_addr", group_addr, it.g);
            check64(it.tag, "avpn", avpn, it.a);
            check64("R4", "group low bits", {57'd0, group_addr[6:0]}, 64'd0);
            last_g = it.g; last_a = it.a; seen_any = 1'b1;
         end
      end else if (seen_any) begin
         check64("R7", "held group_addr", group_addr, last_g);
         check64("R7", "held avpn", avpn, last_a);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: primary vs secondary, small page
      drive(52'h1_2345_6789_ABCD, 1'b0, 64'h0000_0000_0ABC_D123, 64'h0000_0012_3440_000B, 1'b0, "R2");
      drive(52'h1_2345_6789_ABCD, 1'b0, 64'h0000_0000_0ABC_D123, 64'h0000_0012_3440_000B, 1'b1, "R2");
      idle(2);
      // R6: large page, both selects
      drive(52'hA_5A5A_5A5A_5A5A, 1'b1, 64'h0000_0000_0F12_3456, 64'h0000_0040_0000_0010, 1'b0, "R6");
      drive(52'hA_5A5A_5A5A_5A5A, 1'b1, 64'h0000_0000_0F12_3456, 64'h0000_0040_0000_0010, 1'b1, "R6");
      // R5: small page, all-ones identifier
      drive(52'hF_FFFF_FFFF_FFFF, 1'b0, 64'h0000_0000_0765_4FFF, 64'h0000_0000_0004_0005, 1'b0, "R5");
      // R3: size code 0 -> 11-bit mask
      drive(52'h0_0000_0000_07FF, 1'b0, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_0000, 1'b1, "R3");
      drive(52'h0_0000_0003_FFFF, 1'b0, 64'h0000_0000_0FFF_F000, 64'h0000_0000_0000_0003, 1'b0, "R3");
      // R9: size 31, cap at 39 bits
      drive(52'h0_0000_0000_0000, 1'b0, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_001F, 1'b1, "R9");
      drive(52'hF_FFFF_FFFF_FFFF, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_001C, 1'b0, "R9");
      idle(3);
      // R1: high effective-address bits ignored
      drive(52'h0_1234_5678_9ABC, 1'b0, 64'hFFFF_FFFF_F123_4567, 64'h0000_0100_0000_0008, 1'b0, "R1");
      drive(52'h0_1234_5678_9ABC, 1'b1, 64'hDEAD_BEEF_5123_4567, 64'h0000_0100_0000_0008, 1'b1, "R1");
      // R4: spare table bits ignored
      drive(52'h3_3333_3333_3333, 1'b0, 64'h0000_0000_0246_8ACE, 64'h0000_0002_0003_FFE9, 1'b0, "R4");
      idle(1);
      for (int n = 0; n < 40; n++) begin
         drive({$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
               {$urandom, $urandom}, 1'($urandom), "R2");
         if (n % 7 == 3) idle(2);
      end
      idle(4);
      n_checks++;
      if (sb.size() != 0) begin
         n_fails++;
         $display("FAIL R7 results missing: actual %0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule